// File: doc/BRIEF.md
# APB Register Bank with Wait States

This block is an APB subordinate that holds three 32-bit registers: a plain read/write data word, a status word whose bits are set by hardware event inputs and cleared by writing ones, and a counter that advances by one on every write to it. Each ACCESS phase is stretched by a fixed number of wait cycles, chosen by a parameter, before PREADY rises.

Every register update depends on one commit condition: select, enable, write direction and ready all high in the same cycle. As a result, each access changes state exactly once, however long it is stretched. Writes to the data and status words honour the byte strobes. The write decode uses the address of the access in progress. Reads have no side effects.

Top module: `apb_wait_regbank`

## Requirements
- R1: After active-low reset, the data, status and counter registers all read zero, and PREADY and PRDATA are low while idle.
- R2: In every ACCESS phase, PREADY stays low for exactly WAIT_CYCLES cycles and then goes high for one cycle. With WAIT_CYCLES = 0, an access completes in its first ACCESS cycle.
- R3: No register changes during SETUP (PSEL high, PENABLE low) or during an ACCESS cycle in which PREADY is low. The commit happens on the edge that ends the cycle in which PREADY is high.
- R4: A write to the data word (word offset 0x0) updates byte lane n from PWDATA[8n+7:8n] only when PSTRB[n] is 1. Lanes with a 0 strobe keep their previous value.
- R5: A write to the status word (offset 0x4) clears each status bit whose PWDATA bit is 1 and whose byte lane is strobed, applied once per access. Status bits above EVT_W read as zero.
- R6: Each completed write to the counter (offset 0x8) adds exactly one, whatever the data and strobes, including writes stretched by wait states.
- R7: A read access leaves every register unchanged, so repeated reads return the same value.
- R8: Status bit i is set on any clock edge where event input bit i is high. If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: PRDATA is zero whenever the bus is not in a read ACCESS cycle, and it is zero for unmapped offsets. PSLVERR is always low.
- R10: The write decode uses the live PADDR, so back-to-back writes to different offsets each land in their own register.
- R11: A write to an unmapped offset (0xC, or any address with PADDR[1:0] not zero) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Subordinate select |
| penable | input | 1 | ACCESS phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| pstrb | input | DATA_W/8 | Byte-lane write strobes |
| events | input | EVT_W | Hardware event inputs that set status bits |
| pready | output | 1 | Access completion |
| prdata | output | DATA_W | Read data |
| pslverr | output | 1 | Error response, always 0 |

## Verification
PREADY is registered-count driven, so it rises in the ACCESS cycle that follows WAIT_CYCLES stretched cycles. The bench counts the low cycles at each falling edge, starting from the first ACCESS cycle. A register write lands on the rising edge that ends the PREADY-high cycle, so its effect is checked only through a later read access. PRDATA is combinational from the registers during a read ACCESS, and it is sampled at the falling edge of the PREADY-high cycle. An event pulse takes effect one rising edge after it is driven, and the bench reads status only after that edge.

// File: rtl/apb_wait_regbank_pkg.sv
package apb_wait_regbank_pkg;

  localparam int unsigned WORD_DATA   = 0;
  localparam int unsigned WORD_STATUS = 1;
  localparam int unsigned WORD_COUNT  = 2;

  // One-cycle strobes from the control to the datapath
  typedef struct packed {
    logic wrData;
    logic wrStatus;
    logic wrCount;
    logic rdData;
    logic rdStatus;
    logic rdCount;
  } bankStrobes_t;

endpackage

// File: rtl/apb_wait_ctrl.sv
module apb_wait_ctrl
  import apb_wait_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              pready,
  output bankStrobes_t      strobes
);

  localparam int unsigned CNT_W = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;

  logic accessPhase;
  logic waitDone;
  logic commit;
  logic readPhase;
  logic aligned;
  logic [ADDR_W-3:0] wordIdx;

  assign accessPhase = psel && penable;

  generate
    if (WAIT_CYCLES == 0) begin : g_noWait
      assign waitDone = 1'b1;
    end else begin : g_wait
      logic [CNT_W-1:0] waitCnt;
      always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn)                       waitCnt <= '0;
        else if (accessPhase && !waitDone)  waitCnt <= waitCnt + 1'b1;
        else                                waitCnt <= '0;
      end
      assign waitDone = (waitCnt == CNT_W'(WAIT_CYCLES));
    end
  endgenerate

  assign pready    = accessPhase && waitDone;
  // Full commit term: select, enable, direction and completion together
  assign commit    = psel && penable && pwrite && pready;
  assign readPhase = accessPhase && !pwrite;

  // Live address of the current access, never a registered copy
  assign aligned = (paddr[1:0] == 2'b00);
  assign wordIdx = paddr[ADDR_W-1:2];

  always_comb begin
    strobes          = '0;
    strobes.wrData   = commit && aligned && (wordIdx == (ADDR_W-2)'(WORD_DATA));
    strobes.wrStatus = commit && aligned && (wordIdx == (ADDR_W-2)'(WORD_STATUS));
    strobes.wrCount  = commit && aligned && (wordIdx == (ADDR_W-2)'(WORD_COUNT));
    strobes.rdData   = readPhase && aligned && (wordIdx == (ADDR_W-2)'(WORD_DATA));
    strobes.rdStatus = readPhase && aligned && (wordIdx == (ADDR_W-2)'(WORD_STATUS));
    strobes.rdCount  = readPhase && aligned && (wordIdx == (ADDR_W-2)'(WORD_COUNT));
  end

endmodule

// File: rtl/apb_wait_datapath.sv
module apb_wait_datapath
  import apb_wait_regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EVT_W  = 8
) (
  input  logic                pclk,
  input  logic                presetn,
  input  bankStrobes_t        strobes,
  input  logic [DATA_W-1:0]   pwdata,
  input  logic [DATA_W/8-1:0] pstrb,
  input  logic [EVT_W-1:0]    events,
  output logic [DATA_W-1:0]   prdata,
  output logic [DATA_W-1:0]   dataQ,
  output logic [EVT_W-1:0]    statusQ,
  output logic [DATA_W-1:0]   countQ
);

  localparam int unsigned LANES = DATA_W / 8;

  logic [DATA_W-1:0] laneBits;
  logic [EVT_W-1:0]  clearBits;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign laneBits[8*l +: 8] = {8{pstrb[l]}};

      always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn)                      dataQ[8*l +: 8] <= '0;
        else if (strobes.wrData && pstrb[l]) dataQ[8*l +: 8] <= pwdata[8*l +: 8];
      end
    end
  endgenerate

  assign clearBits = strobes.wrStatus ? (pwdata[EVT_W-1:0] & laneBits[EVT_W-1:0]) : '0;

  // Event set takes priority over a same-cycle clear
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) statusQ <= '0;
    else          statusQ <= (statusQ & ~clearBits) | events;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)             countQ <= '0;
    else if (strobes.wrCount) countQ <= countQ + 1'b1;
  end

  always_comb begin
    prdata = '0;
    if (strobes.rdData)   prdata = dataQ;
    if (strobes.rdStatus) prdata = DATA_W'(statusQ);
    if (strobes.rdCount)  prdata = countQ;
  end

endmodule

// File: rtl/apb_wait_regbank.sv
module apb_wait_regbank
  import apb_wait_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned EVT_W       = 8,
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic                pclk,
  input  logic                presetn,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  input  logic [DATA_W/8-1:0] pstrb,
  input  logic [EVT_W-1:0]    events,
  output logic                pready,
  output logic [DATA_W-1:0]   prdata,
  output logic                pslverr
);

  bankStrobes_t      strobes;
  logic [DATA_W-1:0] dataQ;
  logic [EVT_W-1:0]  statusQ;
  logic [DATA_W-1:0] countQ;

  assign pslverr = 1'b0;

  apb_wait_ctrl #(
    .ADDR_W      (ADDR_W),
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_ctrl (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pready  (pready),
    .strobes (strobes)
  );

  apb_wait_datapath #(
    .DATA_W (DATA_W),
    .EVT_W  (EVT_W)
  ) u_dp (
    .pclk    (pclk),
    .presetn (presetn),
    .strobes (strobes),
    .pwdata  (pwdata),
    .pstrb   (pstrb),
    .events  (events),
    .prdata  (prdata),
    .dataQ   (dataQ),
    .statusQ (statusQ),
    .countQ  (countQ)
  );

endmodule

// File: rtl/apb_wait_regbank_chk.sv
module apb_wait_regbank_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EVT_W  = 8
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [EVT_W-1:0]  events,
  input logic              pready,
  input logic [DATA_W-1:0] prdata,
  input logic [DATA_W-1:0] dataQ,
  input logic [EVT_W-1:0]  statusQ,
  input logic [DATA_W-1:0] countQ
);

  logic countAddr;
  assign countAddr = (paddr == ADDR_W'(8));

  // R2: ready only inside ACCESS
  p_ready_in_access_r2: assert property (@(posedge pclk) disable iff (!presetn)
    pready |-> (psel && penable));

  // R3: SETUP leaves data and counter alone
  p_setup_quiet_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !penable) |=> ($stable(dataQ) && $stable(countQ)));

  // R3: waiting ACCESS cycles leave data and counter alone
  p_wait_quiet_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pready) |=> ($stable(dataQ) && $stable(countQ)));

  // R7: reads have no side effects
  p_read_quiet_r7: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pwrite) |=> ($stable(dataQ) && $stable(countQ)));

  // R6: a completed counter write adds exactly one
  p_count_once_r6: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && pready && countAddr) |=> (countQ == $past(countQ) + 1'b1));

  // R8: an event bit is set on the next edge, even against a clear
  p_event_wins_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (|events) |=> ((statusQ & $past(events)) == $past(events)));

  // R9: read data is zero outside read ACCESS
  p_rdata_idle_r9: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && !pwrite) |-> (prdata == '0));

endmodule

bind apb_wait_regbank apb_wait_regbank_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .EVT_W  (EVT_W)
) u_chk (
  .pclk    (pclk),
  .presetn (presetn),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .events  (events),
  .pready  (pready),
  .prdata  (prdata),
  .dataQ   (dataQ),
  .statusQ (statusQ),
  .countQ  (countQ)
);

// File: tb/apb_wait_regbank_tb.sv
module apb_wait_regbank_tb;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned EVT_W  = 8;
  localparam int unsigned WAITS  = 2;

  logic              pclk = 1'b0;
  logic              presetn;
  logic              psel, penable, pwrite;
  logic [ADDR_W-1:0] paddr;
  logic [DATA_W-1:0] pwdata;
  logic [3:0]        pstrb;
  logic [EVT_W-1:0]  events;
  logic              pready;
  logic [DATA_W-1:0] prdata;
  logic              pslverr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] mData = '0;
  logic [7:0]  mStatus = '0;
  logic [31:0] mCount = '0;

  always #2.5 pclk = ~pclk;

  apb_wait_regbank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_W(EVT_W), .WAIT_CYCLES(WAITS)
  ) u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
    .events(events), .pready(pready), .prdata(prdata), .pslverr(pslverr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Access: SETUP, then ACCESS until pready; counts wait cycles (R2)
  task automatic apbAccess(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                           input logic [3:0] st, input logic [7:0] evtAtEnd,
                           output logic [31:0] rd);
    int waitsSeen = 0;
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = wr; paddr = addr; pwdata = wd; pstrb = st;
    @(negedge pclk);
    penable = 1;
    while (!pready && waitsSeen < 20) begin
      if (wr) chk("R9 prdata during write", prdata, 32'h0);
      waitsSeen++;
      @(negedge pclk);
    end
    chk("R2 wait cycles", 32'(waitsSeen), 32'(WAITS));
    rd = prdata;
    events = evtAtEnd;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0; events = '0;
    chk("R9 pslverr", {31'b0, pslverr}, 32'h0);
  endtask

  task automatic apbWrite(input logic [7:0] addr, input logic [31:0] wd, input logic [3:0] st);
    logic [31:0] dummy;
    apbAccess(1'b1, addr, wd, st, 8'h00, dummy);
  endtask

  task automatic readCheck(input string req, input logic [7:0] addr, input logic [31:0] exp);
    logic [31:0] rd;
    apbAccess(1'b0, addr, 32'h0, 4'h0, 8'h00, rd);
    chk(req, rd, exp);
  endtask

  task automatic pulseEvents(input logic [7:0] m);
    @(negedge pclk); events = m;
    @(negedge pclk); events = '0;
    mStatus = mStatus | m;
  endtask

  initial begin
    presetn = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0;
    pwdata = '0; pstrb = '0; events = '0;
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);

    // R1: reset state
    chk("R1 pready idle", {31'b0, pready}, 32'h0);
    chk("R1 prdata idle", prdata, 32'h0);
    readCheck("R1 data reset", 8'h00, 32'h0);
    readCheck("R1 status reset", 8'h04, 32'h0);
    readCheck("R1 count reset", 8'h08, 32'h0);

    // R4 lane sweep, interleaved with counter writes (R6, R10)
    for (int s = 0; s < 16; s++) begin
      logic [31:0] pat;
      pat = 32'hA55A_3CC3 ^ (32'(s) * 32'h0101_0101);
      apbWrite(8'h00, pat, 4'(s));
      for (int l = 0; l < 4; l++)
        if (s[l]) mData[8*l +: 8] = pat[8*l +: 8];
      apbWrite(8'h08, ~pat, 4'(15 - s));
      mCount = mCount + 1;
      readCheck("R4 R10 data lanes", 8'h00, mData);
    end
    readCheck("R6 count after stretched writes", 8'h08, mCount);
    readCheck("R7 count reread", 8'h08, mCount);
    readCheck("R7 data reread", 8'h00, mData);

    // R5, R8: status behaviour
    pulseEvents(8'hF3);
    readCheck("R8 events set", 8'h04, {24'h0, mStatus});
    apbWrite(8'h04, 32'hFFFF_FF31, 4'b0001);
    mStatus = mStatus & ~8'h31;
    readCheck("R5 w1c clear", 8'h04, {24'h0, mStatus});
    apbWrite(8'h04, 32'h0000_00FF, 4'b0000);
    readCheck("R5 unstrobed clear ignored", 8'h04, {24'h0, mStatus});
    begin
      logic [31:0] dummy;
      apbAccess(1'b1, 8'h04, 32'h0000_0082, 4'b0001, 8'h02, dummy);
    end
    mStatus = (mStatus & ~8'h82) | 8'h02;
    readCheck("R8 set wins over clear", 8'h04, {24'h0, mStatus});
    readCheck("R7 status reread", 8'h04, {24'h0, mStatus});

    // R11: unmapped and misaligned writes change nothing
    apbWrite(8'h0C, 32'hFFFF_FFFF, 4'hF);
    apbWrite(8'h01, 32'hFFFF_FFFF, 4'hF);
    apbWrite(8'h09, 32'hFFFF_FFFF, 4'hF);
    readCheck("R11 data untouched", 8'h00, mData);
    readCheck("R11 status untouched", 8'h04, {24'h0, mStatus});
    readCheck("R11 count untouched", 8'h08, mCount);
    readCheck("R9 unmapped read zero", 8'h0C, 32'h0);

    // R6: count with zero strobes still increments once
    apbWrite(8'h08, 32'h0, 4'h0);
    mCount = mCount + 1;
    readCheck("R6 count zero strobe", 8'h08, mCount);

    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge pclk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule